// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block produces a single active-high pulse, with a complementary active-low copy, whenever one of three gated trigger events occurs. The pulse length is a count of system clock cycles taken from an input bus when the pulse starts. If a new valid event arrives while the pulse is still running, the count reloads to its full value. A stream of events can therefore hold the output high for as long as the stream continues. An active-low clear input ends any pulse at once and blocks all triggering while it is low. A rising edge on that same clear input is also a trigger event.

The three trigger inputs are asynchronous to the system clock. Each one passes through a synchronizer chain, and its edges are found by comparing the latest synchronized sample with the one before it. A down-counter produces the pulse. Both outputs come from registers. With the default two-stage synchronizer, an input change shows up at the outputs on the third rising clock edge after it.

Top module: `retrig_oneshot`

## Requirements
- R1: A falling edge on `trig_fall_i` starts a pulse only while `trig_rise_i` is 1 and `clr_n_i` is 1. `pulse_o` then goes high on the third clock edge after the input change and stays high for exactly `len_i` cycles.
- R2: A rising edge on `trig_rise_i` starts a pulse of `len_i` cycles, with the same latency, only while `trig_fall_i` is 0 and `clr_n_i` is 1.
- R3: A rising edge on `clr_n_i` starts a pulse of `len_i` cycles when, at that moment, `trig_fall_i` is 0 and `trig_rise_i` is 1. It starts no pulse otherwise.
- R4: An edge on a trigger input whose gating level is not met starts no pulse. Examples are a falling edge on `trig_fall_i` while `trig_rise_i` is 0, and a rising edge on `trig_rise_i` while `trig_fall_i` is 1.
- R5: While `clr_n_i` is 0, `pulse_o` is driven low starting on the third clock edge after the fall of `clr_n_i`. This ends any pulse in progress, and every trigger edge is ignored.
- R6: A valid trigger during a running pulse reloads the full length. The pulse then ends `len_i` cycles after the last trigger.
- R7: `pulse_n_o` is always the complement of `pulse_o`.
- R8: A gating level that becomes blocking after a pulse has started does not shorten that pulse.
- R9: A `len_i` value of 0 is treated as 1.
- R10: While `rst` is high, the outputs are `pulse_o`=0 and `pulse_n_o`=1, and trigger edges are ignored. Input levels present at the release of `rst` cause no pulse.
- R11: Two trigger paths that become valid in the same cycle (for example, `clr_n_i` and `trig_rise_i` rising together) produce a single pulse of exactly `len_i` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| len_i | input | CNT_W | Pulse length in cycles, sampled at each pulse start |
| trig_fall_i | input | 1 | Falling-edge trigger, gated by `trig_rise_i` high |
| trig_rise_i | input | 1 | Rising-edge trigger, gated by `trig_fall_i` low |
| clr_n_i | input | 1 | Active-low clear; its rising edge is also a trigger |
| pulse_o | output | 1 | Pulse output, active high |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
The assertions assume that `len_i` is stable whenever a trigger can load it. They also assume that the trigger inputs do not change during `rst` in a way that is expected to produce a pulse. The stimulus sets `len_i` once per scenario, well before any trigger edge, and changes no input until the synchronizer has settled. Every trigger input is held for several clock cycles, so each edge that is applied is seen by the synchronizer and none is lost between two samples.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  // Synchronized trigger levels, one field per input pin.
  typedef struct packed {
    logic fall_in;   // falling-edge trigger
    logic rise_in;   // rising-edge trigger
    logic clr_n;     // active-low clear, rising edge triggers
  } trig_bus_t;

  localparam int TRIG_W = $bits(trig_bus_t);

  // Index of each trigger path in the fire vector.
  typedef enum int {
    PATH_FALL = 0,
    PATH_RISE = 1,
    PATH_CLR  = 2
  } path_e;

  localparam int NUM_PATHS = 3;
endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  // Under reset every stage takes the live level, so the history starts equal to the pins.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= d_i;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/os_trig_qual.sv
module os_trig_qual
  import oneshot_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  trig_bus_t cur_i,
  output logic      start_o,
  output logic      arm_o
);
  trig_bus_t            prv_q;
  logic [NUM_PATHS-1:0] fire;

  // History register tracks the synchronized levels in reset too, so the first
  // compare after reset sees no edge unless the pins really moved.
  always_ff @(posedge clk) begin
    if (rst) prv_q <= cur_i;
    else     prv_q <= cur_i;
  end

  always_comb begin
    fire = '0;
    fire[PATH_FALL] = prv_q.fall_in & ~cur_i.fall_in & cur_i.rise_in & cur_i.clr_n;
    fire[PATH_RISE] = ~prv_q.rise_in & cur_i.rise_in & ~cur_i.fall_in & cur_i.clr_n;
    fire[PATH_CLR]  = ~prv_q.clr_n & cur_i.clr_n & ~cur_i.fall_in & cur_i.rise_in;
  end

  // Several paths may fire together; they merge into one load request.
  assign start_o = |fire;
  assign arm_o   = cur_i.clr_n;

  // R5: nothing may start while the clear level is active
  p_no_start_in_clr_r5: assert property (@(posedge clk) disable iff (rst)
    !arm_o |-> !start_o);

  // R4: a falling-edge event never starts a pulse while the rise input is low
  p_fall_gated_r4: assert property (@(posedge clk) disable iff (rst)
    (!cur_i.rise_in && !cur_i.clr_n == 1'b0 && prv_q.rise_in == cur_i.rise_in
     && prv_q.clr_n == cur_i.clr_n && !(prv_q.fall_in == 1'b0 && cur_i.fall_in == 1'b0 && 1'b0))
    |-> !(start_o && !cur_i.rise_in));
endmodule

// File: rtl/os_counter.sv
module os_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             q_o,
  output logic             qn_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] len_eff;

  assign len_eff = (len_i == '0) ? ONE : len_i;

  always_comb begin
    cnt_nxt = cnt_q;
    if (!arm_i)             cnt_nxt = '0;
    else if (start_i)       cnt_nxt = len_eff;
    else if (cnt_q != '0)   cnt_nxt = cnt_q - ONE;
  end

  // Both outputs are registered from the next count, so they change with the counter.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      q_o   <= 1'b0;
      qn_o  <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      q_o   <= (cnt_nxt != '0);
      qn_o  <= (cnt_nxt == '0);
    end
  end

  // R1: an accepted start drives the output high on the next edge
  p_start_high_r1: assert property (@(posedge clk) disable iff (rst)
    (start_i && arm_i) |=> q_o);

  // R5: the clear level forces the output low on the next edge
  p_clear_low_r5: assert property (@(posedge clk) disable iff (rst)
    !arm_i |=> !q_o);

  // R8: with more than one cycle left, nothing but the clear ends the pulse
  p_no_early_end_r8: assert property (@(posedge clk) disable iff (rst)
    (arm_i && cnt_q > ONE) |=> q_o);

  // R6: without a new start the pulse ends when its last cycle is used up
  p_expire_r6: assert property (@(posedge clk) disable iff (rst)
    (arm_i && !start_i && cnt_q == ONE) |=> !q_o);

  // R7: the two outputs are always opposite
  p_complement_r7: assert property (@(posedge clk) disable iff (rst)
    q_o != qn_o);

  // R10: reset leaves the outputs idle
  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> (!q_o && qn_o));
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import oneshot_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] len_i,
  input  logic             trig_fall_i,
  input  logic             trig_rise_i,
  input  logic             clr_n_i,
  output logic             pulse_o,
  output logic             pulse_n_o
);
  logic [TRIG_W-1:0] raw_in;
  logic [TRIG_W-1:0] sync_out;
  trig_bus_t         lvl;
  logic              start;
  logic              arm;

  assign raw_in = {trig_fall_i, trig_rise_i, clr_n_i};
  assign lvl    = trig_bus_t'(sync_out);

  os_sync #(
    .W      (TRIG_W),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (sync_out)
  );

  os_trig_qual qual_i (
    .clk     (clk),
    .rst     (rst),
    .cur_i   (lvl),
    .start_o (start),
    .arm_o   (arm)
  );

  os_counter #(
    .CNT_W (CNT_W)
  ) cnt_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .arm_i   (arm),
    .len_i   (len_i),
    .q_o     (pulse_o),
    .qn_o    (pulse_n_o)
  );

  // R11: a start request always yields a high output afterwards, however many paths fired
  p_merged_start_r11: assert property (@(posedge clk) disable iff (rst)
    (start && arm) |=> (pulse_o && !pulse_n_o));
endmodule

// File: tb/retrig_oneshot_tb_top.sv
`timescale 1ns/1ps
module retrig_oneshot_tb_top;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] len = 8'd5;
  logic             a = 1'b1;
  logic             b = 1'b1;
  logic             rd = 1'b1;
  logic             q;
  logic             qn;

  int n_chk  = 0;
  int n_fail = 0;
  bit comp_bad = 1'b0;

  always #4 clk = ~clk;

  retrig_oneshot #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .len_i       (len),
    .trig_fall_i (a),
    .trig_rise_i (b),
    .clr_n_i     (rd),
    .pulse_o     (q),
    .pulse_n_o   (qn)
  );

  typedef struct packed {
    logic [2:0] pre;   // {a, b, rd} before the event
    logic [2:0] post;  // {a, b, rd} after the event
    logic [7:0] len;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{3'b111, 3'b011, 8'd5},  // R1 valid falling edge
    '{3'b101, 3'b001, 8'd5},  // R4 fall blocked by rise input low
    '{3'b001, 3'b011, 8'd4},  // R2 valid rising edge
    '{3'b101, 3'b111, 8'd4},  // R4 rise blocked by fall input high
    '{3'b010, 3'b011, 8'd7},  // R3 clear rising edge triggers
    '{3'b110, 3'b111, 8'd7},  // R3 clear rise blocked by fall input high
    '{3'b000, 3'b001, 8'd7},  // R3 clear rise blocked by rise input low
    '{3'b110, 3'b010, 8'd6},  // R5 fall ignored while clear low
    '{3'b000, 3'b010, 8'd6},  // R5 rise ignored while clear low
    '{3'b000, 3'b011, 8'd6},  // R11 clear and rise edges together
    '{3'b001, 3'b011, 8'd0},  // R9 zero length acts as one
    '{3'b111, 3'b011, 8'd1},  // R1 shortest pulse
    '{3'b101, 3'b011, 8'd8}   // R11 fall and rise edges together
  };

  // Reference model taken from the requirement text.
  function automatic int model_width(logic [2:0] pre, logic [2:0] post, logic [7:0] ln);
    logic f_a, f_b, f_r;
    f_a = pre[2] & ~post[2] & post[1] & post[0];
    f_b = ~pre[1] & post[1] & ~post[2] & post[0];
    f_r = ~pre[0] & post[0] & ~post[2] & post[1];
    if (!(f_a | f_b | f_r)) return 0;
    return (ln == 0) ? 1 : int'(ln);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] v);
    a  = v[2];
    b  = v[1];
    rd = v[0];
  endtask

  task automatic sample(input int i, inout int hi, inout int first);
    if (q !== ~qn) comp_bad = 1'b1;
    if (q === 1'b1) begin
      hi++;
      if (first < 0) first = i;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int hi, first;
    // R10: outputs idle in reset; a valid-looking edge during reset is ignored
    repeat (5) @(negedge clk);
    chk("R10 reset pulse_o", int'(q), 0);
    chk("R10 reset pulse_n_o", int'(qn), 1);
    a = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    hi = 0; first = -1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      sample(i, hi, first);
    end
    chk("R10 no pulse after reset release", hi, 0);

    // Table walk: R1 R2 R3 R4 R5 R9 R11
    for (int v = 0; v < NV; v++) begin
      int exp_w;
      len = VEC[v].len;
      put(VEC[v].pre);
      repeat (20) @(negedge clk);
      put(VEC[v].post);
      exp_w = model_width(VEC[v].pre, VEC[v].post, VEC[v].len);
      hi = 0; first = -1;
      for (int i = 1; i <= 25; i++) begin
        @(negedge clk);
        sample(i, hi, first);
      end
      chk($sformatf("table vector %0d width", v), hi, exp_w);
      if (exp_w > 0) chk($sformatf("R1 latency vector %0d", v), first, 3);
    end

    // R6: retrigger after a gap reloads the full length
    len = 8'd10;
    put(3'b111);
    repeat (20) @(negedge clk);
    a = 1'b0;
    hi = 0; first = -1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      sample(i, hi, first);
      if (i == 5) a = 1'b1;
      if (i == 7) a = 1'b0;
    end
    chk("R6 retrigger width", hi, 17);
    chk("R6 retrigger start", first, 3);

    // R5: clear cuts a long pulse; triggers while clear is low do nothing
    len = 8'd20;
    put(3'b111);
    repeat (30) @(negedge clk);
    a = 1'b0;
    hi = 0; first = -1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      sample(i, hi, first);
      if (i == 6)  rd = 1'b0;
      if (i == 15) a = 1'b1;
      if (i == 20) a = 1'b0;
    end
    chk("R5 early clear width", hi, 6);

    // R8: blocking level applied mid-pulse does not shorten it
    len = 8'd8;
    put(3'b111);
    repeat (20) @(negedge clk);
    a = 1'b0;
    hi = 0; first = -1;
    for (int i = 1; i <= 25; i++) begin
      @(negedge clk);
      sample(i, hi, first);
      if (i == 4) b = 1'b0;
    end
    chk("R8 pulse kept under blocking level", hi, 8);

    // R7: complement held at every sample taken
    chk("R7 complement", int'(comp_bad), 0);

    summary();
    $finish;
  end
endmodule